// File: doc/BRIEF.md
# Compressed Block Address Calculator

This block turns the index of an uncompressed 64-byte block inside a compressed page into the byte position of that block in the page's packed layout. A page holds 128 blocks grouped into 8 sub-pages of 16 blocks. Every block is stored at one of four quantised sizes, and every sub-page has one of four allocation sizes. The page itself also has one of four size classes. The per-page size codes arrive from an on-die size table that sits beside the address translation cache. The block position is the sum of the allocations of all earlier sub-pages plus the stored sizes of the earlier blocks in the same sub-page.

The calculator also reports the allocated size of the addressed block. It raises a flag when that block is stored as all zeros, so a load can be answered without touching memory. When a freshly compressed size is offered, the block reports whether that size needs a larger or a smaller size class. It also reports whether the addressed sub-page would then outgrow its allocation or fit a smaller one. A further flag shows that the sub-page allocations together exceed the page's size class, which is the cue for software to move the page. All results are registered, so they are valid one clock after the inputs are presented.

Top module: `cblk_addr_calc`

## Requirements
- R1: The 2-bit block size code maps to stored bytes as 0→0, 1→22, 2→44, 3→64, and `blk_alloc` shows the stored size of the addressed block. Block b uses bits [2b+1:2b] of `blk_codes`.
- R2: `zero_blk` is 1 exactly when the addressed block's size code is 0.
- R3: `blk_offset` equals the sum, over sub-pages before the addressed one, of 256·(code+1) bytes, plus the stored sizes of the earlier blocks in the same sub-page. Sub-page s uses bits [2s+1:2s] of `sub_codes`.
- R4: `page_ovf` is 1 when the sum of all eight sub-page allocations exceeds 2048·(`page_code`+1) bytes.
- R5: The size class that a new size needs is 0 for 0 bytes, 1 for 1–22, 2 for 23–44, and 3 for anything above 44. With `size_upd` high, `blk_ovf` is set when the needed class is above the current code, and `blk_unf` is set when it is below. With `size_upd` low, both flags are 0.
- R6: The sub-page sum is the sum of the stored sizes of the 16 blocks of the addressed sub-page, with the addressed block taken at its needed class when `size_upd` is high. `sub_ovf` is set when this sum exceeds the sub-page allocation A. `sub_unf` is set when A > 256 and the sum is at most A−256.
- R7: Outputs change one clock after the inputs are sampled. While `rst_n` is low, every output is 0.
- R8: `blk_idx[6:4]` selects the sub-page and `blk_idx[3:0]` selects the block within it. The block's bit position in `blk_codes` is the full index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_codes | input | 256 | Per-block 2-bit size codes of the page |
| sub_codes | input | 16 | Per-sub-page 2-bit allocation codes |
| page_code | input | 2 | Page size class |
| blk_idx | input | 7 | Uncompressed block index |
| new_size | input | 7 | Newly compressed size in bytes |
| size_upd | input | 1 | New size is offered for the addressed block |
| blk_offset | output | 14 | Byte offset of the block in the compressed page |
| blk_alloc | output | 7 | Stored size of the addressed block |
| zero_blk | output | 1 | Addressed block holds only zeros |
| blk_ovf | output | 1 | New size needs a larger block class |
| blk_unf | output | 1 | New size fits a smaller block class |
| sub_ovf | output | 1 | Sub-page sum exceeds its allocation |
| sub_unf | output | 1 | Sub-page sum fits a smaller allocation |
| page_ovf | output | 1 | Sub-page allocations exceed the page class |

## Verification
The assertions assume that the inputs are held at defined values throughout reset and that `size_upd` stays low until reset is released. This matters because several properties look one cycle back at `size_upd`, `blk_idx` and `page_code`. The stimulus is applied on falling edges, starting with all inputs zero during reset. Every later vector is a legal code pattern, so any value on the code inputs is in range. The new sizes swept include values above 64 to exercise saturation to the top class.

// File: rtl/cblk_addr_calc.sv
module cblk_addr_calc #(
  parameter int SUBS = 8,
  parameter int BLKS = 16,
  localparam int NB  = SUBS * BLKS,
  localparam int IW  = $clog2(NB),
  localparam int BW  = $clog2(BLKS),
  localparam int OW  = $clog2(NB * 64 + 1),
  localparam int SUB_Q  = BLKS * 16,
  localparam int PAGE_Q = NB * 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2*NB-1:0] blk_codes,
  input  logic [2*SUBS-1:0] sub_codes,
  input  logic [1:0]      page_code,
  input  logic [IW-1:0]   blk_idx,
  input  logic [6:0]      new_size,
  input  logic            size_upd,
  output logic [OW-1:0]   blk_offset,
  output logic [6:0]      blk_alloc,
  output logic            zero_blk,
  output logic            blk_ovf,
  output logic            blk_unf,
  output logic            sub_ovf,
  output logic            sub_unf,
  output logic            page_ovf
);

  function automatic logic [6:0] blk_bytes(input logic [1:0] c);
    case (c)
      2'd0: blk_bytes = 7'd0;
      2'd1: blk_bytes = 7'd22;
      2'd2: blk_bytes = 7'd44;
      default: blk_bytes = 7'd64;
    endcase
  endfunction

  function automatic logic [1:0] need_cls(input logic [6:0] n);
    if (n == 7'd0)       need_cls = 2'd0;
    else if (n <= 7'd22) need_cls = 2'd1;
    else if (n <= 7'd44) need_cls = 2'd2;
    else                 need_cls = 2'd3;
  endfunction

  function automatic logic [OW-1:0] sub_bytes(input logic [1:0] c);
    sub_bytes = OW'(SUB_Q) * (OW'(c) + OW'(1));
  endfunction

  logic [IW-BW-1:0] s_sel;
  logic [BW-1:0]    b_sel;
  logic [1:0]       cur_code, req_code;
  logic [OW-1:0]    sub_pre, in_pre, sub_sum, sub_alloc, page_tot, page_cap;

  assign s_sel     = blk_idx[IW-1:BW];
  assign b_sel     = blk_idx[BW-1:0];
  assign cur_code  = blk_codes[2*blk_idx +: 2];
  assign req_code  = need_cls(new_size);
  assign sub_alloc = sub_bytes(sub_codes[2*s_sel +: 2]);
  assign page_cap  = OW'(PAGE_Q) * (OW'(page_code) + OW'(1));

  always_comb begin
    sub_pre  = '0;
    page_tot = '0;
    for (int j = 0; j < SUBS; j++) begin
      page_tot = page_tot + sub_bytes(sub_codes[2*j +: 2]);
      if (j < int'(s_sel)) sub_pre = sub_pre + sub_bytes(sub_codes[2*j +: 2]);
    end
  end

  always_comb begin
    logic [1:0] c, e;
    in_pre  = '0;
    sub_sum = '0;
    for (int k = 0; k < BLKS; k++) begin
      c = blk_codes[2*(int'(s_sel)*BLKS + k) +: 2];
      e = (k == int'(b_sel) && size_upd) ? req_code : c;
      if (k < int'(b_sel)) in_pre = in_pre + OW'(blk_bytes(c));
      sub_sum = sub_sum + OW'(blk_bytes(e));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_offset <= '0;
      blk_alloc  <= '0;
      zero_blk   <= 1'b0;
      blk_ovf    <= 1'b0;
      blk_unf    <= 1'b0;
      sub_ovf    <= 1'b0;
      sub_unf    <= 1'b0;
      page_ovf   <= 1'b0;
    end else begin
      blk_offset <= sub_pre + in_pre;
      blk_alloc  <= blk_bytes(cur_code);
      zero_blk   <= (cur_code == 2'd0);
      blk_ovf    <= size_upd && (req_code > cur_code);
      blk_unf    <= size_upd && (req_code < cur_code);
      sub_ovf    <= sub_sum > sub_alloc;
      sub_unf    <= (sub_alloc > OW'(SUB_Q)) && (sub_sum <= sub_alloc - OW'(SUB_Q));
      page_ovf   <= page_tot > page_cap;
    end
  end

endmodule

// File: rtl/cblk_addr_calc_chk.sv
module cblk_addr_calc_chk #(
  parameter int SUBS = 8,
  parameter int BLKS = 16,
  localparam int NB  = SUBS * BLKS,
  localparam int IW  = $clog2(NB),
  localparam int OW  = $clog2(NB * 64 + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    page_code,
  input logic [IW-1:0] blk_idx,
  input logic          size_upd,
  input logic [OW-1:0] blk_offset,
  input logic [6:0]    blk_alloc,
  input logic          blk_ovf,
  input logic          blk_unf,
  input logic          sub_ovf,
  input logic          sub_unf,
  input logic          page_ovf
);

  // R1
  alloc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_alloc == 7'd0 || blk_alloc == 7'd22 || blk_alloc == 7'd44 || blk_alloc == 7'd64);

  // R3
  first_blk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(blk_idx) == '0 |-> blk_offset == '0);

  // R4
  page_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(page_code) == 2'd3 |-> !page_ovf);

  // R5
  blk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(size_upd) |-> (!blk_ovf && !blk_unf));

  // R5
  blk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(blk_ovf && blk_unf));

  // R6
  sub_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sub_ovf && sub_unf));

endmodule

bind cblk_addr_calc cblk_addr_calc_chk #(.SUBS(SUBS), .BLKS(BLKS)) chk (.*);

// File: tb/cblk_addr_calc_test.sv
module cblk_addr_calc_test;
  logic         clk = 0, rst_n = 0;
  logic [255:0] blk_codes = '0;
  logic [15:0]  sub_codes = '0;
  logic [1:0]   page_code = '0;
  logic [6:0]   blk_idx = '0, new_size = '0;
  logic         size_upd = 0;
  logic [13:0]  blk_offset;
  logic [6:0]   blk_alloc;
  logic zero_blk, blk_ovf, blk_unf, sub_ovf, sub_unf, page_ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cblk_addr_calc uut (.*);

  function automatic int bsz(int c);
    return c == 0 ? 0 : c == 1 ? 22 : c == 2 ? 44 : 64;
  endfunction
  function automatic int ncls(int n);
    return n == 0 ? 0 : n <= 22 ? 1 : n <= 44 ? 2 : 3;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(int idx, int ns, bit upd);
    int s, b, off, tot, ssum, a, cur, rq, c;
    @(negedge clk);
    blk_idx = 7'(idx); new_size = 7'(ns); size_upd = upd;
    @(posedge clk); #1;
    s = idx / 16; b = idx % 16;
    off = 0; tot = 0; ssum = 0;
    for (int j = 0; j < 8; j++) begin
      tot += 256 * (int'(sub_codes[2*j +: 2]) + 1);
      if (j < s) off += 256 * (int'(sub_codes[2*j +: 2]) + 1);
    end
    cur = int'(blk_codes[2*idx +: 2]);
    rq = ncls(ns);
    for (int k = 0; k < 16; k++) begin
      c = int'(blk_codes[2*(s*16+k) +: 2]);
      if (k < b) off += bsz(c);
      ssum += (k == b && upd) ? bsz(rq) : bsz(c);
    end
    a = 256 * (int'(sub_codes[2*s +: 2]) + 1);
    chk("R3/R8 offset", blk_offset, off);
    chk("R1 alloc", blk_alloc, bsz(cur));
    chk("R2 zero", zero_blk, cur == 0);
    chk("R5 blk_ovf", blk_ovf, upd && rq > cur);
    chk("R5 blk_unf", blk_unf, upd && rq < cur);
    chk("R6 sub_ovf", sub_ovf, ssum > a);
    chk("R6 sub_unf", sub_unf, a > 256 && ssum <= a - 256);
    chk("R4 page_ovf", page_ovf, tot > 2048 * (int'(page_code) + 1));
  endtask

  task automatic load(int mode);
    @(negedge clk);
    for (int i = 0; i < 128; i++) blk_codes[2*i +: 2] = mode == 0 ? 2'd0 : mode == 1 ? 2'd3 : 2'($urandom);
    for (int i = 0; i < 8; i++) sub_codes[2*i +: 2] = mode == 0 ? 2'd0 : mode == 1 ? 2'd3 : 2'($urandom);
    page_code = mode == 0 ? 2'd0 : mode == 1 ? 2'd3 : 2'($urandom);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R7 reset offset", blk_offset, 0);
    chk("R7 reset flags", {zero_blk, blk_ovf, blk_unf, sub_ovf, sub_unf, page_ovf}, 0);
    @(negedge clk); rst_n = 1;
    for (int m = 0; m < 8; m++) begin
      load(m);
      for (int i = 0; i < 128; i++) apply(i, 0, 0);
      for (int n = 0; n <= 70; n++) begin
        apply(0, n, 1);
        apply(37, n, 1);
        apply(127, n, 1);
      end
    end
    @(negedge clk); rst_n = 0;
    @(posedge clk); #1;
    chk("R7 reset again", {blk_offset, blk_alloc}, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (150000) @(posedge clk); errors++; $display("FAIL watchdog: got 0 expected 1"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule